// File: doc/BRIEF.md
# Character I/O Flag and Interrupt Cycle Controller

This block sits beside the instruction sequencer of a small 16-bit accumulator machine. It keeps the two device handshake flags (input character waiting, output device ready), the interrupt enable bit and the interrupt pending bit. It holds the 8-bit input and output character registers. It decodes the six I/O instructions during the execute step and drives strobes back to the sequencer: an accumulator OR-load for character input, a program counter skip, and the register strobes of a three-step interrupt cycle.

The sequencer supplies its step count and the current instruction word. While the pending bit is set, the sequencer replaces its normal fetch with the interrupt steps. Those steps save the program counter at word 0, continue execution at word 1, and disable further interrupts. A service routine returns with an indirect branch through word 0.

Top module: `io_intr_unit`

## Requirements
- R1: After reset the input flag is 0, the output-ready flag is 1, interrupt enable is 0, the pending bit is 0, both character registers are 0 and every strobe is low.
- R2: A cycle with `devInStrobe` high loads `devInData` into the input character register and sets the input flag at the next edge.
- R3: An I/O instruction is decoded only when `timeStep` is 3, `iBit` is 1 and `irWord[14:12]` is 3'b111. Any other combination drives no I/O strobe and changes no flag. The function is picked by a set bit: bit 11 input, bit 10 output, bit 9 skip on input, bit 8 skip on output, bit 7 enable, bit 6 disable.
- R4: Input raises `acOrEn` in the execute cycle and clears the input flag at the next edge. A device strobe in the same cycle wins, so the flag stays set and the new character is kept.
- R5: Output raises `outrLoad`, loads `acLow` into the output register and clears the output-ready flag. This clear wins over `devOutDone` in the same cycle.
- R6: Skip on input (or skip on output) raises `pcInc` in the execute cycle exactly when the input flag (or output-ready flag) is 1.
- R7: Enable sets interrupt enable at the next edge. Disable clears it.
- R8: The pending bit is set at an edge whose cycle has `timeStep` of 3 or more, interrupt enable at 1 and either flag at 1. It is never set by a cycle with `timeStep` 0 to 2.
- R9: While pending, step 0 raises `arClr` and `trLoadPc`. Step 1 raises `memWrTr` and `pcClr`. Step 2 raises `pcInc` and `scClr`, and clears both interrupt enable and the pending bit at the next edge.
- R10: While not pending, `arClr`, `trLoadPc`, `memWrTr`, `pcClr` and `scClr` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeStep | input | 4 | Sequence counter value from the sequencer |
| irWord | input | 16 | Current instruction word |
| iBit | input | 1 | Addressing-mode flip-flop |
| acLow | input | 8 | Low byte of the accumulator |
| devInStrobe | input | 1 | Input device delivers a character |
| devInData | input | 8 | Character from the input device |
| devOutDone | input | 1 | Output device has finished its character |
| inprData | output | 8 | Input character register, ORed into the accumulator on `acOrEn` |
| outrData | output | 8 | Output character register |
| acOrEn | output | 1 | OR `inprData` into the accumulator low byte |
| outrLoad | output | 1 | Output character accepted, device now busy |
| pcInc | output | 1 | Increment the program counter |
| arClr | output | 1 | Clear the address register |
| trLoadPc | output | 1 | Copy the program counter into the temporary register |
| memWrTr | output | 1 | Write the temporary register to memory at the address register |
| pcClr | output | 1 | Clear the program counter |
| scClr | output | 1 | Clear the sequence counter |
| intCycle | output | 1 | Pending bit: the sequencer runs interrupt steps in place of fetch |
| fgiFlag | output | 1 | Input character waiting |
| fgoFlag | output | 1 | Output device ready |
| ienFlag | output | 1 | Interrupt enable |

## Verification
Every flag is brought out, so a flag that is set or cleared wrongly shows on its port one edge after the cycle that caused it. The same wrong value also changes the skip strobe of the next skip instruction. A pending bit set too early or too late shows as interrupt-step strobes at a step count where none are expected. A stuck pending bit shows as a missing clear after step 2. The vectors include same-cycle collisions between device events and the instructions that clear the flags. They also include disabling interrupts in the very step that still arms the pending bit.

// File: rtl/io_intr_pkg.sv
package io_intr_pkg;
  // Strobes from control to the flag/register datapath
  typedef struct packed {
    logic inpDo;
    logic outDo;
    logic ionDo;
    logic iofDo;
    logic intDone;
    logic setPend;
  } ioStrobes_t;

  localparam int NUM_IO_OPS = 6;
  localparam int EXEC_STEP  = 3;
  localparam int INT_STEPS  = 3;
endpackage

// File: rtl/io_intr_ctrl.sv
module io_intr_ctrl
  import io_intr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SC_W   = 4
) (
  input  logic [SC_W-1:0]   timeStep,
  input  logic [WORD_W-1:0] irWord,
  input  logic              iBit,
  input  logic              intCycle,
  input  logic              fgiFlag,
  input  logic              fgoFlag,
  input  logic              ienFlag,
  output ioStrobes_t        strb,
  output logic              pcInc,
  output logic              arClr,
  output logic              trLoadPc,
  output logic              memWrTr,
  output logic              pcClr,
  output logic              scClr
);
  localparam int OPC_HI = WORD_W - 2;
  localparam int OPC_LO = WORD_W - 4;
  localparam int SEL_HI = WORD_W - 5;
  localparam int SEL_LO = SEL_HI - NUM_IO_OPS + 1;

  logic [INT_STEPS-1:0]  rStep;
  logic [NUM_IO_OPS-1:0] sel;
  logic                  ioStep;
  logic                  skipHit;

  // One decoded strobe per interrupt-cycle step
  for (genvar k = 0; k < INT_STEPS; k++) begin : gRStep
    assign rStep[k] = intCycle && (timeStep == SC_W'(k));
  end

  assign ioStep = !intCycle && iBit && (&irWord[OPC_HI:OPC_LO])
                  && (timeStep == SC_W'(EXEC_STEP));
  assign sel    = ioStep ? irWord[SEL_HI:SEL_LO] : '0;

  // sel[5]=input, [4]=output, [3]=skip in, [2]=skip out, [1]=enable, [0]=disable
  assign skipHit = (sel[3] && fgiFlag) || (sel[2] && fgoFlag);

  always_comb begin
    strb.inpDo   = sel[5];
    strb.outDo   = sel[4];
    strb.ionDo   = sel[1];
    strb.iofDo   = sel[0];
    strb.intDone = rStep[2];
    strb.setPend = (timeStep >= SC_W'(EXEC_STEP)) && ienFlag && (fgiFlag || fgoFlag);
  end

  assign arClr    = rStep[0];
  assign trLoadPc = rStep[0];
  assign memWrTr  = rStep[1];
  assign pcClr    = rStep[1];
  assign scClr    = rStep[2];
  assign pcInc    = rStep[2] || skipHit;
endmodule

// File: rtl/io_intr_regs.sv
module io_intr_regs
  import io_intr_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strb,
  input  logic [CHAR_W-1:0] acLow,
  input  logic              devInStrobe,
  input  logic [CHAR_W-1:0] devInData,
  input  logic              devOutDone,
  output logic              fgiFlag,
  output logic              fgoFlag,
  output logic              ienFlag,
  output logic              intCycle,
  output logic [CHAR_W-1:0] inprData,
  output logic [CHAR_W-1:0] outrData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fgiFlag  <= 1'b0;
      fgoFlag  <= 1'b1;
      ienFlag  <= 1'b0;
      intCycle <= 1'b0;
      inprData <= '0;
      outrData <= '0;
    end else begin
      // new character wins over the input instruction's clear
      if (devInStrobe)     fgiFlag <= 1'b1;
      else if (strb.inpDo) fgiFlag <= 1'b0;
      // output instruction's clear wins over device done
      if (strb.outDo)      fgoFlag <= 1'b0;
      else if (devOutDone) fgoFlag <= 1'b1;
      if (strb.ionDo)                     ienFlag <= 1'b1;
      else if (strb.iofDo || strb.intDone) ienFlag <= 1'b0;
      if (strb.intDone)      intCycle <= 1'b0;
      else if (strb.setPend) intCycle <= 1'b1;
      if (devInStrobe) inprData <= devInData;
      if (strb.outDo)  outrData <= acLow;
    end
  end
endmodule

// File: rtl/io_intr_unit.sv
module io_intr_unit
  import io_intr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SC_W   = 4,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SC_W-1:0]   timeStep,
  input  logic [WORD_W-1:0] irWord,
  input  logic              iBit,
  input  logic [CHAR_W-1:0] acLow,
  input  logic              devInStrobe,
  input  logic [CHAR_W-1:0] devInData,
  input  logic              devOutDone,
  output logic [CHAR_W-1:0] inprData,
  output logic [CHAR_W-1:0] outrData,
  output logic              acOrEn,
  output logic              outrLoad,
  output logic              pcInc,
  output logic              arClr,
  output logic              trLoadPc,
  output logic              memWrTr,
  output logic              pcClr,
  output logic              scClr,
  output logic              intCycle,
  output logic              fgiFlag,
  output logic              fgoFlag,
  output logic              ienFlag
);
  ioStrobes_t strb;

  io_intr_ctrl #(.WORD_W(WORD_W), .SC_W(SC_W)) uCtrl (
    .timeStep(timeStep), .irWord(irWord), .iBit(iBit),
    .intCycle(intCycle), .fgiFlag(fgiFlag), .fgoFlag(fgoFlag), .ienFlag(ienFlag),
    .strb(strb), .pcInc(pcInc), .arClr(arClr), .trLoadPc(trLoadPc),
    .memWrTr(memWrTr), .pcClr(pcClr), .scClr(scClr)
  );

  io_intr_regs #(.CHAR_W(CHAR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .acLow(acLow),
    .devInStrobe(devInStrobe), .devInData(devInData), .devOutDone(devOutDone),
    .fgiFlag(fgiFlag), .fgoFlag(fgoFlag), .ienFlag(ienFlag),
    .intCycle(intCycle), .inprData(inprData), .outrData(outrData)
  );

  assign acOrEn   = strb.inpDo;
  assign outrLoad = strb.outDo;
endmodule

// File: rtl/io_intr_chk.sv
module io_intr_chk #(
  parameter int SC_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [SC_W-1:0] timeStep,
  input logic            devInStrobe,
  input logic            outrLoad,
  input logic            arClr,
  input logic            trLoadPc,
  input logic            memWrTr,
  input logic            pcClr,
  input logic            scClr,
  input logic            intCycle,
  input logic            fgiFlag,
  input logic            fgoFlag,
  input logic            ienFlag
);
  AST_INPUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    devInStrobe |=> fgiFlag); // R2

  AST_OUT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    outrLoad |=> !fgoFlag); // R5

  AST_PEND_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (timeStep >= SC_W'(3)) && ienFlag && (fgiFlag || fgoFlag) |=> intCycle); // R8

  AST_NO_EARLY_PEND: assert property (@(posedge clk) disable iff (!rstN)
    !intCycle && (timeStep <= SC_W'(2)) |=> !intCycle); // R8

  AST_STEP0_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    intCycle && (timeStep == SC_W'(0)) |-> arClr && trLoadPc && !memWrTr && !scClr); // R9

  AST_STEP2_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    intCycle && (timeStep == SC_W'(2)) |=> !intCycle && !ienFlag); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !intCycle |-> !arClr && !trLoadPc && !memWrTr && !pcClr && !scClr); // R10
endmodule

bind io_intr_unit io_intr_chk #(.SC_W(SC_W)) uChk (
  .clk(clk), .rstN(rstN), .timeStep(timeStep), .devInStrobe(devInStrobe),
  .outrLoad(outrLoad), .arClr(arClr), .trLoadPc(trLoadPc), .memWrTr(memWrTr),
  .pcClr(pcClr), .scClr(scClr), .intCycle(intCycle),
  .fgiFlag(fgiFlag), .fgoFlag(fgoFlag), .ienFlag(ienFlag)
);

// File: tb/tb_io_intr_unit.sv
module tb_io_intr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  timeStep = '0;
  logic [15:0] irWord = '0;
  logic        iBit = 1'b0;
  logic [7:0]  acLow = '0;
  logic        devInStrobe = 1'b0;
  logic [7:0]  devInData = '0;
  logic        devOutDone = 1'b0;
  logic [7:0]  inprData, outrData;
  logic        acOrEn, outrLoad, pcInc, arClr, trLoadPc, memWrTr, pcClr, scClr;
  logic        intCycle, fgiFlag, fgoFlag, ienFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  io_intr_unit dut (.*);

  // {req, step, iBit, ir, ac, devIn, devData, devDone,
  //  strobes{pcInc,acOrEn,outrLoad,arClr,trLoadPc,memWrTr,pcClr,scClr},
  //  flags{fgi,fgo,ien,pend}, outr, inpr}
  localparam int NV = 23;
  localparam logic [70:0] VEC [NV] = '{
    {4'd6, 4'd3,1'b1,16'hF200,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0100,8'h00,8'h00}, // R6 skip in, flag 0
    {4'd6, 4'd3,1'b1,16'hF100,8'h00,1'b0,8'h00,1'b0,8'b10000000,4'b0100,8'h00,8'h00}, // R6 skip out, flag 1
    {4'd5, 4'd3,1'b1,16'hF400,8'h5A,1'b0,8'h00,1'b1,8'b00100000,4'b0000,8'h5A,8'h00}, // R5 clear beats done
    {4'd2, 4'd1,1'b0,16'h0000,8'h00,1'b1,8'hC3,1'b0,8'b00000000,4'b1000,8'h5A,8'hC3}, // R2 char arrives
    {4'd6, 4'd3,1'b1,16'hF200,8'h00,1'b0,8'h00,1'b0,8'b10000000,4'b1000,8'h5A,8'hC3}, // R6 skip in taken
    {4'd3, 4'd3,1'b0,16'hF800,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b1000,8'h5A,8'hC3}, // R3 mode bit 0
    {4'd3, 4'd2,1'b1,16'hF800,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b1000,8'h5A,8'hC3}, // R3 wrong step
    {4'd4, 4'd3,1'b1,16'hF800,8'h00,1'b1,8'h7E,1'b0,8'b01000000,4'b1000,8'h5A,8'h7E}, // R4 device wins
    {4'd4, 4'd3,1'b1,16'hF800,8'h00,1'b0,8'h00,1'b0,8'b01000000,4'b0000,8'h5A,8'h7E}, // R4 input clears
    {4'd7, 4'd3,1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0010,8'h5A,8'h7E}, // R7 enable
    {4'd8, 4'd5,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b1,8'b00000000,4'b0110,8'h5A,8'h7E}, // R8 flag old 0
    {4'd8, 4'd1,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0110,8'h5A,8'h7E}, // R8 early step
    {4'd8, 4'd4,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0111,8'h5A,8'h7E}, // R8 arms
    {4'd9, 4'd0,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00011000,4'b0111,8'h5A,8'h7E}, // R9 step 0
    {4'd9, 4'd1,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00000110,4'b0111,8'h5A,8'h7E}, // R9 step 1
    {4'd9, 4'd2,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b10000001,4'b0100,8'h5A,8'h7E}, // R9 step 2
    {4'd10,4'd4,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0100,8'h5A,8'h7E}, // R10 disabled
    {4'd7, 4'd3,1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0110,8'h5A,8'h7E}, // R7 enable again
    {4'd7, 4'd3,1'b1,16'hF040,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0101,8'h5A,8'h7E}, // R7 disable, still arms
    {4'd9, 4'd0,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00011000,4'b0101,8'h5A,8'h7E}, // R9
    {4'd9, 4'd1,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b00000110,4'b0101,8'h5A,8'h7E}, // R9
    {4'd9, 4'd2,1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,8'b10000001,4'b0100,8'h5A,8'h7E}, // R9
    {4'd3, 4'd3,1'b1,16'hE800,8'h00,1'b0,8'h00,1'b0,8'b00000000,4'b0100,8'h5A,8'h7E}  // R3 not 111
  };

  function automatic logic [7:0] strobes();
    return {pcInc, acOrEn, outrLoad, arClr, trLoadPc, memWrTr, pcClr, scClr};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    check(1, "reset strobes", 32'(strobes()), 32'h0);
    check(1, "reset flags", 32'({fgiFlag, fgoFlag, ienFlag, intCycle}), 32'b0100);
    check(1, "reset chars", 32'({outrData, inprData}), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      timeStep    = VEC[v][66:63];
      iBit        = VEC[v][62];
      irWord      = VEC[v][61:46];
      acLow       = VEC[v][45:38];
      devInStrobe = VEC[v][37];
      devInData   = VEC[v][36:29];
      devOutDone  = VEC[v][28];
      #1;
      check(int'(VEC[v][70:67]), $sformatf("vec %0d strobes", v), 32'(strobes()), 32'(VEC[v][27:20]));
      @(posedge clk);
      #1;
      check(int'(VEC[v][70:67]), $sformatf("vec %0d flags", v),
            32'({fgiFlag, fgoFlag, ienFlag, intCycle}), 32'(VEC[v][19:16]));
      check(int'(VEC[v][70:67]), $sformatf("vec %0d chars", v),
            32'({outrData, inprData}), 32'(VEC[v][15:0]));
    end
    // R1 directed: reset again mid-run restores every register
    @(negedge clk);
    devInStrobe = 1'b0; devOutDone = 1'b0; timeStep = 4'd3; iBit = 1'b1; irWord = 16'hF080;
    @(negedge clk);
    rstN = 1'b0; timeStep = 4'd0; irWord = 16'h0000;
    #1;
    check(1, "re-reset flags", 32'({fgiFlag, fgoFlag, ienFlag, intCycle}), 32'b0100);
    check(1, "re-reset chars", 32'({outrData, inprData}), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule